// File: doc/BRIEF.md
# Iterative block cipher round sequencer

This block steps a 128-bit block cipher through its rounds, one round per clock, over a single 128-bit state register. A start pulse captures a plaintext block and a key-size select. In that same cycle the plaintext is XORed with the whitening key, which is round key 0. The block then counts through the full rounds and ends with a final round that has no column mixing. There are 10 rounds for a 128-bit key, 12 for a 192-bit key and 14 for a 256-bit key.

The substitution, row rotation and column mixing logic sits outside this block, and so does the key schedule. Both are reached through combinational ports. The sequencer presents its current state and a last-round flag. It takes back the transformed state before the key is added. It presents a round index and a normalized key size, and takes back the matching 128-bit round key. Each cycle it XORs that key into the transformed state. While idle, the round index is 0, so the key source presents the whitening key. For every key size that key is the first 128 bits of the cipher key, which for a 256-bit key is its first half. When the final round completes, the block pulses a done flag and latches the result into a separate register. That register holds its value until the next run completes.

Top module: `aes_round_seq`

## Requirements
- R1: After reset, busy_o and done_o are 0, rk_idx_o is 0, ks_o follows the normalized select, and rf_state_o and ct_o are all zeros.
- R2: A start_i sampled while busy_o is low loads the state with pt_i XOR rk_i. In that cycle rk_idx_o is 0. In the next cycle busy_o is 1 and rk_idx_o is 1.
- R3: In every busy cycle the state is replaced by rf_i XOR rk_i, and rf_state_o always shows the current state.
- R4: While busy, rk_idx_o rises by one each cycle from 1 up to the round count N. N is 10 for select 00, 12 for select 01 and 14 for select 10 or 11. rf_last_o is high exactly in the cycle where rk_idx_o equals N.
- R5: In the cycle right after the round-N cycle, done_o is 1 for one cycle, busy_o is 0, rk_idx_o is 0, and ct_o equals the rf_i XOR rk_i of the round-N cycle.
- R6: While busy_o is high, start_i, pt_i and ksel_i have no effect. The round sequence, the state and ks_o go on unchanged.
- R7: ct_o changes only in the cycle in which done_o rises. A start accepted in the done cycle begins a new run immediately, and ct_o keeps the previous result through that run.
- R8: ks_o is the normalized key size (00 = 128, 01 = 192, 10 = 256, with select 11 given as 10). While busy it holds the value captured at start. While idle it follows ksel_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted when not busy |
| pt_i | input | 128 | Plaintext block |
| ksel_i | input | 2 | Key-size select |
| rk_idx_o | output | 4 | Index of the round key wanted this cycle |
| ks_o | output | 2 | Normalized key size for the key source |
| rk_i | input | 128 | Round key for rk_idx_o |
| rf_state_o | output | 128 | Current state, sent to the round function |
| rf_last_o | output | 1 | Final round: round function skips column mixing |
| rf_i | input | 128 | Round function output before key addition |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ct_o | output | 128 | Result register |

## Verification
Completion and acceptance of a new start can fall in the same cycle. The done pulse drops busy_o, so a start held high is taken in that very cycle. The bench keeps start_i high across whole runs with every key size, so each run begins in the previous run's done cycle. The behavioural model then judges, on every clock, that the new state is the whitened plaintext, that rk_idx_o restarts at 1, and that ct_o keeps the earlier result until the new run's own done pulse.

// File: rtl/aes_round_seq.sv
module aes_round_seq #(
  parameter int BLK   = 128,
  parameter int NR128 = 10,
  parameter int NR192 = 12,
  parameter int NR256 = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [BLK-1:0] pt_i,
  input  logic [1:0]     ksel_i,
  output logic [$clog2(NR256+1)-1:0] rk_idx_o,
  output logic [1:0]     ks_o,
  input  logic [BLK-1:0] rk_i,
  output logic [BLK-1:0] rf_state_o,
  output logic           rf_last_o,
  input  logic [BLK-1:0] rf_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [BLK-1:0] ct_o
);
  localparam int IW = $clog2(NR256 + 1);

  logic [BLK-1:0] st_q, ct_q;
  logic [IW-1:0]  idx_q, nr_q;
  logic [1:0]     ks_q, ks_in;
  logic           busy_q, done_q, last;

  function automatic logic [IW-1:0] rounds_for(input logic [1:0] ks);
    case (ks)
      2'b00:   return IW'(NR128);
      2'b01:   return IW'(NR192);
      default: return IW'(NR256);
    endcase
  endfunction

  assign ks_in      = (ksel_i == 2'b11) ? 2'b10 : ksel_i;
  assign last       = busy_q && (idx_q == nr_q);
  assign rk_idx_o   = idx_q;
  assign ks_o       = busy_q ? ks_q : ks_in;
  assign rf_state_o = st_q;
  assign rf_last_o  = last;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign ct_o       = ct_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      ct_q   <= '0;
      idx_q  <= '0;
      nr_q   <= '0;
      ks_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          st_q   <= pt_i ^ rk_i;
          busy_q <= 1'b1;
          idx_q  <= IW'(1);
          ks_q   <= ks_in;
          nr_q   <= rounds_for(ks_in);
        end
      end else begin
        st_q <= rf_i ^ rk_i;
        if (last) begin
          ct_q   <= rf_i ^ rk_i;
          done_q <= 1'b1;
          busy_q <= 1'b0;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assert_idle_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> rk_idx_o == '0);

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && rk_idx_o == IW'(1)));

  assert_index_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !rf_last_o) |=> (busy_o && rk_idx_o == $past(rk_idx_o) + 1'b1));

  assert_index_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (rk_idx_o >= IW'(NR128) || !rf_last_o) && rk_idx_o <= IW'(NR256) && rk_idx_o != '0);

  assert_done_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_last_o |=> (done_o && !busy_o));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_ks_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(ks_o));

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(ct_o));
endmodule

// File: tb/aes_round_seq_tb.sv
module aes_round_seq_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [127:0] pt_i = '0;
  logic [1:0]   ksel_i = 2'b00;
  logic [3:0]   rk_idx_o;
  logic [1:0]   ks_o;
  logic [127:0] rk_i, rf_state_o, rf_i, ct_o;
  logic         rf_last_o, busy_o, done_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  function automatic logic [127:0] key_of(input int idx, input logic [1:0] ks);
    logic [31:0] w;
    w = (32'h9E3779B9 * (idx + 1)) ^ {30'b0, ks};
    return {w, ~w, w ^ 32'h5A5A5A5A, w + 32'h1};
  endfunction

  function automatic logic [127:0] round_of(input logic [127:0] s, input logic lst);
    if (lst) return {s[119:0], s[127:120]} ^ 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;
    return {s[111:0], s[127:112]} ^ {s[63:0], s[127:64]} ^ 128'h1;
  endfunction

  assign rk_i = key_of(int'(rk_idx_o), ks_o);
  assign rf_i = round_of(rf_state_o, rf_last_o);

  aes_round_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pt_i(pt_i), .ksel_i(ksel_i),
    .rk_idx_o(rk_idx_o), .ks_o(ks_o), .rk_i(rk_i), .rf_state_o(rf_state_o),
    .rf_last_o(rf_last_o), .rf_i(rf_i), .busy_o(busy_o), .done_o(done_o), .ct_o(ct_o)
  );

  logic [127:0] m_state = '0, m_ct = '0;
  int           m_idx = 0, m_nr = 0;
  logic [1:0]   m_ks = 2'b00;
  logic         m_busy = 1'b0, m_done = 1'b0;

  function automatic logic [1:0] norm(input logic [1:0] k);
    return (k == 2'b11) ? 2'b10 : k;
  endfunction

  function automatic int nr_of(input logic [1:0] k);
    return (k == 2'b00) ? 10 : (k == 2'b01) ? 12 : 14;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [1:0] vks;
    vks = m_busy ? m_ks : norm(ksel_i);
    chk((m_busy && m_idx == 1) ? "R2" : "R3", "rf_state_o", rf_state_o, m_state);
    chk("R4", "rk_idx_o", 128'(rk_idx_o), m_busy ? 128'(m_idx) : 128'd0);
    chk("R4", "rf_last_o", 128'(rf_last_o), 128'(m_busy && m_idx == m_nr));
    chk("R6", "busy_o", 128'(busy_o), 128'(m_busy));
    chk("R5", "done_o", 128'(done_o), 128'(m_done));
    chk("R7", "ct_o", ct_o, m_ct);
    chk("R8", "ks_o", 128'(ks_o), 128'(vks));
  endtask

  task automatic cyc(input logic st, input logic [127:0] pt, input logic [1:0] ks);
    logic [1:0]   vks;
    logic [127:0] key, nxt;
    logic         lst;
    start_i = st; pt_i = pt; ksel_i = ks;
    vks = m_busy ? m_ks : norm(ks);
    key = key_of(m_busy ? m_idx : 0, vks);
    m_done = 1'b0;
    if (!m_busy) begin
      if (st) begin
        m_state = pt ^ key;
        m_busy  = 1'b1;
        m_idx   = 1;
        m_ks    = norm(ks);
        m_nr    = nr_of(norm(ks));
      end
    end else begin
      lst = (m_idx == m_nr);
      nxt = round_of(m_state, lst) ^ key;
      m_state = nxt;
      if (lst) begin
        m_ct = nxt; m_done = 1'b1; m_busy = 1'b0; m_idx = 0;
      end else begin
        m_idx++;
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    ksel_i = 2'b01;
    #1;
    // R1: reset state
    chk("R1", "busy_o", 128'(busy_o), 128'd0);
    chk("R1", "done_o", 128'(done_o), 128'd0);
    chk("R1", "rk_idx_o", 128'(rk_idx_o), 128'd0);
    chk("R1", "ct_o", ct_o, 128'd0);
    chk("R1", "rf_state_o", rf_state_o, 128'd0);
    chk("R1", "ks_o", 128'(ks_o), 128'd1);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(0, '0, 2'b00);
    cyc(0, '0, 2'b11);
    // R4/R5: one run per key size, single-cycle start
    for (int k = 0; k < 4; k++) begin
      cyc(1, {32'h01234567, 32'h89ABCDEF, 32'(k), 32'hFEDCBA98}, 2'(k));
      for (int i = 0; i < 17; i++) cyc(0, 128'(i * 7), 2'(k + 1));
    end
    // R6: start, data and select toggled during a run
    cyc(1, 128'hDEADBEEF_00112233_44556677_8899AABB, 2'b00);
    for (int i = 0; i < 14; i++) cyc(i[0], {4{32'(i)}}, 2'(i));
    cyc(0, '0, 2'b00);
    // R7: start held high, runs back to back
    for (int i = 0; i < 60; i++)
      cyc(1, {8{16'(i * 257 + 3)}}, 2'(i / 15));
    for (int i = 0; i < 20; i++) cyc(0, '0, 2'(i));
    summary();
  end
endmodule